// File: doc/BRIEF.md
# Prescaled Up/Down Charge Counter with Threshold Alert

This block keeps a running battery charge figure in a 16-bit accumulator. An upstream integrator, not part of this block, turns current into single-cycle event pulses, each tagged with a direction: charge in or charge out. A power-of-two prescaler, selected by a 3-bit exponent in the control byte, passes one step to the accumulator for every 2^n events of the same direction. The accumulator starts at mid-scale after reset because the battery state is unknown. It stops at both ends of its range and never wraps. Firmware can load the accumulator and the two threshold registers directly. It can also freeze counting through a shutdown bit in the control byte.

Two sticky flags record when the charge figure has risen above the high threshold or fallen below the low threshold. Reading status clears both flags. The shared pin has three modes, chosen by control bits [2:1]. In alert mode the block drives an active-low alert while any flag is set. In charge-complete mode an externally driven high level on the pin presets the accumulator to full scale. In the off mode the pin does nothing.

A two-state machine drives the alert. In AL_QUIET the alert is released. The transition "raise" moves it to AL_ACTIVE when alert mode is selected and a flag is set. The transition "release" returns it to AL_QUIET when both flags are clear or alert mode is left.

Top module: `coulomb_gauge`

## Requirements
- R1: After reset the accumulator reads 7FFFh, the control byte reads 3Ch (exponent 111, pin mode alert, counting on), the high threshold reads FFFFh, the low threshold reads 0000h, both flags are 0 and alert_n is 1.
- R2: With exponent code n in control bits [5:3], the accumulator moves one step for every 2^n sampled events of the same direction. An event whose direction differs from the previous event restarts the run and counts as its first event.
- R3: evt_up=1 counts toward an increment and evt_up=0 toward a decrement. A step shows on acc_q right after the clock edge that samples the completing event.
- R4: The accumulator saturates. A step up at FFFFh leaves FFFFh, and a step down at 0000h leaves 0000h.
- R5: While control bit 0 is 1, events change neither the accumulator nor the prescaler run.
- R6: acc_we loads acc_wdata at the next edge, and this load wins over a step in the same cycle. thr_hi_we and thr_lo_we load thr_wdata into the high or low threshold, and ctrl_we loads the control byte.
- R7: flag_hi sets one edge after acc_q > thr_hi_q is seen, and flag_lo sets one edge after acc_q < thr_lo_q is seen. Each flag stays set until a status read.
- R8: A stat_rd pulse clears both flags at its edge. A condition that still holds sets its flag again one edge later.
- R9: With pin mode 10b (alert), alert_n goes to 0 one edge after a flag is seen set and returns to 1 one edge after both flags are seen clear. In any other pin mode alert_n stays 1.
- R10: With pin mode 01b (charge-complete), cc_pin=1 loads FFFFh into the accumulator at the next edge, ahead of loads and steps. In other modes cc_pin has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 1 | One-cycle charge event |
| evt_up | input | 1 | Event direction, 1 = charge in |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| acc_we | input | 1 | Accumulator write strobe |
| acc_wdata | input | 16 | Accumulator write data |
| thr_hi_we | input | 1 | High threshold write strobe |
| thr_lo_we | input | 1 | Low threshold write strobe |
| thr_wdata | input | 16 | Threshold write data |
| stat_rd | input | 1 | Status read strobe, clears flags |
| cc_pin | input | 1 | Sensed level of the shared pin (charge complete) |
| ctrl_q | output | 8 | Control byte |
| acc_q | output | 16 | Accumulated charge |
| thr_hi_q | output | 16 | High threshold |
| thr_lo_q | output | 16 | Low threshold |
| flag_hi | output | 1 | Sticky above-high flag |
| flag_lo | output | 1 | Sticky below-low flag |
| alert_n | output | 1 | Active-low alert drive |

## Verification
The bench builds the block with its default parameters: a 16-bit accumulator and a 3-bit exponent, which give prescale factors up to 128. Writes to the control byte bring the small exponents 0 and 2 within reach. With those, direction restarts and complete runs take only a few events. Accumulator loads placed near 0000h and FFFFh reach both saturation edges within a few events. A long random phase mixes events, mode changes, loads and status reads, and a behavioural model is compared against the block on every cycle.

// File: rtl/gauge_pkg.sv
package gauge_pkg;

    typedef enum logic [1:0] {
        PIN_OFF   = 2'b00,
        PIN_CC    = 2'b01,
        PIN_ALERT = 2'b10,
        PIN_RSVD  = 2'b11
    } pin_mode_e;

    typedef enum logic {
        AL_QUIET  = 1'b0,
        AL_ACTIVE = 1'b1
    } alert_state_e;

    localparam int CTRL_W      = 8;
    localparam int HALT_BIT    = 0;
    localparam int MODE_LSB    = 1;
    localparam int EXP_LSB     = 3;

endpackage

// File: rtl/gauge_prescaler.sv
module gauge_prescaler #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             evt,
    input  logic             up,
    input  logic [EXP_W-1:0] exp_code,
    output logic             step_up,
    output logic             step_dn
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] limit;
    logic             last_up;
    logic             take;
    logic             fire;

    always_comb begin
        limit   = ~({CNT_W{1'b1}} << exp_code);
        base    = (up == last_up) ? run_cnt : '0;
        take    = enable && evt;
        fire    = take && (base >= limit);
        step_up = fire && up;
        step_dn = fire && !up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            last_up <= 1'b1;
        end else if (take) begin
            last_up <= up;
            run_cnt <= (base >= limit) ? '0 : base + CNT_W'(1);
        end
    end
endmodule

// File: rtl/gauge_accum.sv
module gauge_accum #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             load,
    input  logic [ACC_W-1:0] load_val,
    input  logic             force_full,
    output logic [ACC_W-1:0] acc
);
    localparam logic [ACC_W-1:0] MID  = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] ZERO = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= MID;
        end else if (force_full) begin
            acc <= FULL;
        end else if (load) begin
            acc <= load_val;
        end else if (step_up && acc != FULL) begin
            acc <= acc + ACC_W'(1);
        end else if (step_dn && acc != ZERO) begin
            acc <= acc - ACC_W'(1);
        end
    end
endmodule

// File: rtl/gauge_alert_fsm.sv
module gauge_alert_fsm
    import gauge_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] thr_hi,
    input  logic [ACC_W-1:0] thr_lo,
    input  logic             stat_rd,
    input  logic             alert_en,
    output logic             flag_hi,
    output logic             flag_lo,
    output logic             alert_n
);
    alert_state_e state, state_nx;
    logic         any_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_hi <= 1'b0;
            flag_lo <= 1'b0;
        end else if (stat_rd) begin
            flag_hi <= 1'b0;
            flag_lo <= 1'b0;
        end else begin
            flag_hi <= flag_hi || (acc > thr_hi);
            flag_lo <= flag_lo || (acc < thr_lo);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= AL_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        any_flag = flag_hi || flag_lo;
        state_nx = state;
        unique case (state)
            AL_QUIET:  if (alert_en && any_flag)    state_nx = AL_ACTIVE;
            AL_ACTIVE: if (!alert_en || !any_flag)  state_nx = AL_QUIET;
        endcase
    end

    always_comb begin
        alert_n = (state != AL_ACTIVE);
    end
endmodule

// File: rtl/coulomb_gauge.sv
module coulomb_gauge
    import gauge_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int EXP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_pulse,
    input  logic              evt_up,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              acc_we,
    input  logic [ACC_W-1:0]  acc_wdata,
    input  logic              thr_hi_we,
    input  logic              thr_lo_we,
    input  logic [ACC_W-1:0]  thr_wdata,
    input  logic              stat_rd,
    input  logic              cc_pin,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [ACC_W-1:0]  acc_q,
    output logic [ACC_W-1:0]  thr_hi_q,
    output logic [ACC_W-1:0]  thr_lo_q,
    output logic              flag_hi,
    output logic              flag_lo,
    output logic              alert_n
);
    localparam logic [CTRL_W-1:0] CTRL_RST =
        CTRL_W'({EXP_W{1'b1}}) << EXP_LSB | CTRL_W'(PIN_ALERT) << MODE_LSB;

    pin_mode_e        pin_mode;
    logic [EXP_W-1:0] exp_code;
    logic             count_en;
    logic             force_full;
    logic             step_up, step_dn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RST;
            thr_hi_q <= '1;
            thr_lo_q <= '0;
        end else begin
            if (ctrl_we)   ctrl_q   <= ctrl_wdata;
            if (thr_hi_we) thr_hi_q <= thr_wdata;
            if (thr_lo_we) thr_lo_q <= thr_wdata;
        end
    end

    always_comb begin
        pin_mode   = pin_mode_e'(ctrl_q[MODE_LSB +: 2]);
        exp_code   = ctrl_q[EXP_LSB +: EXP_W];
        count_en   = !ctrl_q[HALT_BIT];
        force_full = (pin_mode == PIN_CC) && cc_pin;
    end

    gauge_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .enable(count_en), .evt(evt_pulse),
        .up(evt_up), .exp_code(exp_code), .step_up(step_up), .step_dn(step_dn)
    );

    gauge_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
        .load(acc_we), .load_val(acc_wdata), .force_full(force_full), .acc(acc_q)
    );

    gauge_alert_fsm #(.ACC_W(ACC_W)) u_alert (
        .clk(clk), .rst_n(rst_n), .acc(acc_q), .thr_hi(thr_hi_q), .thr_lo(thr_lo_q),
        .stat_rd(stat_rd), .alert_en(pin_mode == PIN_ALERT),
        .flag_hi(flag_hi), .flag_lo(flag_lo), .alert_n(alert_n)
    );
endmodule

// File: rtl/gauge_checker.sv
module gauge_checker #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_we,
    input logic             stat_rd,
    input logic             cc_pin,
    input logic [7:0]       ctrl_q,
    input logic [ACC_W-1:0] acc_q,
    input logic             flag_hi,
    input logic             flag_lo,
    input logic             alert_n
);
    logic cc_force;
    assign cc_force = (ctrl_q[2:1] == 2'b01) && cc_pin;

    assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == {ACC_W{1'b1}} && !acc_we) |=> acc_q != '0);

    assert_sat_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == '0 && !acc_we && !cc_force) |=> acc_q != {ACC_W{1'b1}});

    assert_halt_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && !acc_we && !cc_force) |=> $stable(acc_q));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_hi || flag_lo) && !stat_rd) |=> (flag_hi || flag_lo));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (!flag_hi && !flag_lo));

    assert_alert_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> $past(ctrl_q[2:1] == 2'b10));

    assert_cc_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cc_force |=> acc_q == {ACC_W{1'b1}});
endmodule

bind coulomb_gauge gauge_checker #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_we(acc_we), .stat_rd(stat_rd), .cc_pin(cc_pin),
    .ctrl_q(ctrl_q), .acc_q(acc_q), .flag_hi(flag_hi), .flag_lo(flag_lo), .alert_n(alert_n)
);

// File: tb/tb_coulomb_gauge.sv
module tb_coulomb_gauge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pulse = 0, evt_up = 0, ctrl_we = 0, acc_we = 0;
    logic        thr_hi_we = 0, thr_lo_we = 0, stat_rd = 0, cc_pin = 0;
    logic [7:0]  ctrl_wdata = 0;
    logic [15:0] acc_wdata = 0, thr_wdata = 0;
    logic [7:0]  ctrl_q;
    logic [15:0] acc_q, thr_hi_q, thr_lo_q;
    logic        flag_hi, flag_lo, alert_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    coulomb_gauge dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_up(evt_up),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .thr_hi_we(thr_hi_we), .thr_lo_we(thr_lo_we), .thr_wdata(thr_wdata),
        .stat_rd(stat_rd), .cc_pin(cc_pin), .ctrl_q(ctrl_q), .acc_q(acc_q),
        .thr_hi_q(thr_hi_q), .thr_lo_q(thr_lo_q), .flag_hi(flag_hi), .flag_lo(flag_lo),
        .alert_n(alert_n)
    );

    // behavioural reference model
    int  m_acc, m_cnt, m_hi, m_lo;
    bit  m_up, m_fh, m_fl, m_act;
    bit [7:0] m_ctrl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 32767; m_cnt = 0; m_up = 1; m_hi = 65535; m_lo = 0;
            m_fh = 0; m_fl = 0; m_act = 0; m_ctrl = 8'h3C;
        end else begin
            int  lim, b, n_acc, n_cnt;
            bit  n_up, n_fh, n_fl, n_act;
            bit [1:0] mode;
            mode  = m_ctrl[2:1];
            lim   = (1 << m_ctrl[5:3]) - 1;
            n_acc = m_acc; n_cnt = m_cnt; n_up = m_up;
            if (evt_pulse && !m_ctrl[0]) begin
                b    = (evt_up == m_up) ? m_cnt : 0;
                n_up = evt_up;
                if (b >= lim) begin
                    n_cnt = 0;
                    if (evt_up) n_acc = (m_acc < 65535) ? m_acc + 1 : 65535;
                    else        n_acc = (m_acc > 0) ? m_acc - 1 : 0;
                end else n_cnt = b + 1;
            end
            if (acc_we) n_acc = acc_wdata;
            if (mode == 2'b01 && cc_pin) n_acc = 65535;
            n_fh  = stat_rd ? 0 : (m_fh || m_acc > m_hi);
            n_fl  = stat_rd ? 0 : (m_fl || m_acc < m_lo);
            n_act = (mode == 2'b10) && (m_fh || m_fl);
            if (ctrl_we)   m_ctrl = ctrl_wdata;
            if (thr_hi_we) m_hi = thr_wdata;
            if (thr_lo_we) m_lo = thr_wdata;
            m_acc = n_acc; m_cnt = n_cnt; m_up = n_up;
            m_fh = n_fh; m_fl = n_fl; m_act = n_act;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 R3 R4 R6 R10 acc", acc_q, m_acc);
            chk("R7 R8 flag_hi", flag_hi, m_fh);
            chk("R7 R8 flag_lo", flag_lo, m_fl);
            chk("R9 alert_n", alert_n, !m_act);
            chk("R6 ctrl", ctrl_q, m_ctrl);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr_ctrl(logic [7:0] v);
        ctrl_we = 1; ctrl_wdata = v; tick(1); ctrl_we = 0;
    endtask
    task automatic wr_acc(logic [15:0] v);
        acc_we = 1; acc_wdata = v; tick(1); acc_we = 0;
    endtask
    task automatic wr_thr(bit hi, logic [15:0] v);
        thr_hi_we = hi; thr_lo_we = !hi; thr_wdata = v; tick(1);
        thr_hi_we = 0; thr_lo_we = 0;
    endtask
    task automatic pulses(bit up, int n);
        for (int i = 0; i < n; i++) begin
            evt_pulse = 1; evt_up = up; tick(1);
        end
        evt_pulse = 0;
    endtask
    task automatic rd_stat();
        stat_rd = 1; tick(1); stat_rd = 0;
    endtask

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        tick(2);
        chk("R1 acc reset", acc_q, 16'h7FFF);
        chk("R1 ctrl reset", ctrl_q, 8'h3C);
        chk("R1 thr_hi reset", thr_hi_q, 16'hFFFF);
        chk("R1 thr_lo reset", thr_lo_q, 0);
        chk("R1 flags reset", {flag_hi, flag_lo}, 0);
        chk("R1 alert_n reset", alert_n, 1);
        rst_n = 1;
        tick(1);

        wr_ctrl(8'h04);
        pulses(1, 5);
        chk("R3 five up steps exp0", acc_q, 16'h8004);

        wr_ctrl(8'h14);
        pulses(1, 8);
        chk("R2 eight up events exp2", acc_q, 16'h8006);
        pulses(1, 3);
        pulses(0, 3);
        chk("R2 direction restart no step yet", acc_q, 16'h8006);
        pulses(0, 1);
        chk("R2 fourth down steps", acc_q, 16'h8005);

        wr_ctrl(8'h15);
        pulses(1, 10);
        chk("R5 halt ignores events", acc_q, 16'h8005);
        wr_acc(16'hFFFE);
        chk("R6 acc load", acc_q, 16'hFFFE);
        wr_ctrl(8'h04);
        pulses(1, 3);
        chk("R4 saturate at top", acc_q, 16'hFFFF);

        wr_thr(1, 16'h8000);
        chk("R6 thr_hi load", thr_hi_q, 16'h8000);
        tick(1);
        chk("R7 flag_hi set", flag_hi, 1);
        tick(1);
        chk("R9 alert_n low", alert_n, 0);
        rd_stat();
        chk("R8 read clears flag_hi", flag_hi, 0);
        tick(1);
        chk("R8 flag_hi re-set", flag_hi, 1);
        wr_thr(1, 16'hFFFF);
        rd_stat();
        tick(2);
        chk("R8 flag stays clear", flag_hi, 0);
        chk("R9 alert_n released", alert_n, 1);

        wr_acc(16'h0002);
        pulses(0, 5);
        chk("R4 saturate at bottom", acc_q, 0);
        wr_thr(0, 16'h0010);
        tick(1);
        chk("R7 flag_lo set", flag_lo, 1);
        wr_ctrl(8'h00);
        tick(3);
        chk("R9 pin off keeps alert_n high", alert_n, 1);

        wr_ctrl(8'h02);
        cc_pin = 1; tick(1); cc_pin = 0;
        chk("R10 charge complete presets full", acc_q, 16'hFFFF);
        wr_acc(16'h1234);
        wr_ctrl(8'h04);
        cc_pin = 1; tick(2); cc_pin = 0;
        chk("R10 cc_pin ignored in alert mode", acc_q, 16'h1234);

        for (int c = 0; c < 4000; c++) begin
            evt_pulse = ($urandom % 2) == 1;
            evt_up    = ($urandom % 3) != 0;
            ctrl_we   = ($urandom % 60) == 0;
            ctrl_wdata = {2'b00, 3'($urandom % 4), 2'($urandom), ($urandom % 8) == 0};
            acc_we    = ($urandom % 150) == 0;
            acc_wdata = (($urandom % 2) == 1) ? 16'hFFF8 + 16'($urandom % 8) : 16'($urandom % 8);
            thr_hi_we = ($urandom % 200) == 0;
            thr_lo_we = ($urandom % 200) == 0;
            thr_wdata = 16'($urandom);
            stat_rd   = ($urandom % 40) == 0;
            cc_pin    = ($urandom % 50) == 0;
            tick(1);
        end
        {evt_pulse, ctrl_we, acc_we, thr_hi_we, thr_lo_we, stat_rd, cc_pin} = '0;
        tick(2);
        summary();
    end
endmodule